// File: doc/BRIEF.md
# Binary/BCD Calendar Clock Core

This core keeps the time of day and the calendar from a one-cycle strobe that arrives once per second. Each strobe advances seconds, minutes and hours, and on a day boundary also the day of the week, the date, the month and a two-digit year, with February given 29 days in every year divisible by four. The counters are held internally in plain binary 24-hour form. The seven user-visible bytes are produced from them in binary or packed BCD, with the hour shown either as 0 to 23 or as 1 to 12 with a PM flag in bit 7. Both choices are run-time inputs.

The user-visible bytes form a second copy that normally follows the counters one cycle behind. While the freeze input is high this copy holds still, so a reader gets a consistent snapshot, while the counters keep advancing. The copy catches up on the first edge after freeze drops. Each second ends with an update-done pulse. An alarm-hit pulse comes with it when the seconds, minutes and hour alarm bytes each equal the new time or are marked as wildcards. An optional daylight-saving rule moves the hour forward in spring and back in autumn. A load port presets the counters.

Top module: `rtc_calendar_core`

## Requirements
- R1: While rst_n is low, all seven output bytes, upd_done and alarm_hit are 0; the counters reset to 00:00:00, day of week 1, date 1, month 1, year 0.
- R2: Each accepted tick advances seconds; 59 wraps to 0 and carries into minutes, minute 59 wraps to 0 and carries into hours, and hour 23 wraps to 0 and advances the day of week (1 to 7, 7 wraps to 1) and the date.
- R3: The date wraps to 1 after the last day of the month (30 for months 4, 6, 9 and 11, 29 for month 2 when year mod 4 is 0, otherwise 28, and 31 for all other months); month 12 wraps to 1 and carries into the year, and year 99 wraps to 0.
- R4: With bcd_mode=1 every output byte holds the tens digit in bits [7:4] and the units digit in bits [3:0]; with bcd_mode=0 it holds the plain binary value.
- R5: With mode_24h=1 the hour byte is 0 to 23 with bit 7 clear; with mode_24h=0 bits [6:0] carry 1 to 12 (internal hour 0 shows as 12, 13 to 23 show as 1 to 11) and bit 7 is 1 for internal hours 12 to 23.
- R6: With dst_en=1 and day of week 1 (Sunday), a tick at 01:59:59 in month 4 on date 1 to 7 gives 03:00:00; in month 10 on date 25 or later it gives 01:00:00 the first time and 02:00:00 the second time; with dst_en=0 no adjustment is made.
- R7: A tick sampled high with ld_en low at edge E0 changes the counters at E0; upd_done is high for exactly one cycle, from edge E0+1 to E0+2, and the output bytes show the new time from E0+1.
- R8: alarm_hit is high together with upd_done when each of alm_sec, alm_min and alm_hour either equals the corresponding newly encoded time byte (same format and hour mode as the outputs) or has bits [7:6] equal to 11; otherwise it stays low.
- R9: While freeze is high the output bytes hold their values, and the counters, upd_done and alarm_hit keep running.
- R10: On the first edge at which freeze is sampled low, the output bytes show the current counters.
- R11: ld_en sampled high writes the binary 24-hour ld_* values into the counters and clears the daylight-saving fall-back memory; a tick in the same cycle is dropped with no advance and no upd_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| ld_en | input | 1 | Preset the counters from ld_* |
| ld_sec | input | 6 | Preset seconds, binary 0-59 |
| ld_min | input | 6 | Preset minutes, binary 0-59 |
| ld_hour | input | 5 | Preset hour, binary 0-23 |
| ld_dow | input | 3 | Preset day of week, 1-7, 1 = Sunday |
| ld_date | input | 5 | Preset date, 1-31 |
| ld_month | input | 4 | Preset month, 1-12 |
| ld_year | input | 7 | Preset year, 0-99 |
| bcd_mode | input | 1 | 1 = packed BCD bytes, 0 = binary |
| mode_24h | input | 1 | 1 = 24-hour, 0 = 12-hour with PM flag |
| dst_en | input | 1 | Enable daylight-saving adjustment |
| freeze | input | 1 | Hold the user-visible copy |
| alm_sec | input | 8 | Seconds alarm byte, 11 in [7:6] = wildcard |
| alm_min | input | 8 | Minutes alarm byte, 11 in [7:6] = wildcard |
| alm_hour | input | 8 | Hour alarm byte, 11 in [7:6] = wildcard |
| out_sec | output | 8 | User copy: seconds |
| out_min | output | 8 | User copy: minutes |
| out_hour | output | 8 | User copy: hour, bit 7 = PM in 12-hour mode |
| out_dow | output | 8 | User copy: day of week |
| out_date | output | 8 | User copy: date |
| out_month | output | 8 | User copy: month |
| out_year | output | 8 | User copy: year |
| upd_done | output | 1 | One-cycle pulse after each advance |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
The counting chain is first driven through a continuous run of more than an hour across midnight, and then through a run across the last second of a century year. These two runs separate the minute, hour, day-of-week and year carries from each other. Single ticks from the last second of every month in two common years, a leap year and the year-00 boundary isolate the month-length rule. A sweep of every hour through its hh:59:59 tick in both encodings, in 12-hour mode, pins the 12-to-1 wrap and the PM flip against the 24-hour values. Dedicated sequences cover the spring and autumn daylight-saving Sundays against ordinary Sundays and a disabled rule, exact, wildcard and PM alarm patterns, a freeze window that spans several ticks, and a load that coincides with a tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int FIELD_CNT = 7;
   localparam int IDX_SEC   = 0;
   localparam int IDX_MIN   = 1;
   localparam int IDX_HOUR  = 2;
   localparam int IDX_DOW   = 3;
   localparam int IDX_DATE  = 4;
   localparam int IDX_MONTH = 5;
   localparam int IDX_YEAR  = 6;

   typedef struct packed {
      logic [5:0] sec;
      logic [5:0] min;
      logic [4:0] hour;
      logic [2:0] dow;
      logic [4:0] date;
      logic [3:0] month;
      logic [6:0] year;
   } rtc_time_t;

   // Binary value 0..99 to a presentation byte
   function automatic logic [7:0] enc_value(input logic [6:0] v, input logic bcd);
      logic [3:0] tens;
      logic [3:0] ones;
      tens = 4'(v / 7'd10);
      ones = 4'(v % 7'd10);
      return bcd ? {tens, ones} : {1'b0, v};
   endfunction

   // Internal 24-hour value to the hour byte for the selected mode
   function automatic logic [7:0] enc_hour(input logic [6:0] h, input logic bcd,
                                           input logic h24);
      logic [6:0] h12;
      logic [7:0] b;
      if (h24) begin
         b = enc_value(h, bcd);
      end else begin
         if (h == 7'd0)       h12 = 7'd12;
         else if (h > 7'd12)  h12 = h - 7'd12;
         else                 h12 = h;
         b = enc_value(h12, bcd);
         b[7] = (h >= 7'd12);
      end
      return b;
   endfunction

   function automatic logic [4:0] days_in(input logic [3:0] m, input logic [6:0] y);
      logic [4:0] d;
      case (m)
         4'd2:                     d = (y[1:0] == 2'b00) ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11:  d = 5'd30;
         default:                  d = 5'd31;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
   import rtc_cal_pkg::*;
#(
   parameter int YEAR_MAX = 99,
   parameter bit DST_OPT  = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      adv,
   input  logic      ld_en,
   input  rtc_time_t ld_val,
   input  logic      dst_on,
   output rtc_time_t now
);

   localparam logic [6:0] YEAR_TOP = 7'(YEAR_MAX);

   rtc_time_t cur_q, nxt;
   logic      fall_q, fall_d;
   logic      dst_gate;
   logic      roll_min, roll_hr, roll_day, roll_mon, roll_yr;
   logic      spring_fwd, fall_back;

   generate
      if (DST_OPT) begin : g_dst
         assign dst_gate = dst_on;
      end else begin : g_no_dst
         assign dst_gate = 1'b0;
      end
   endgenerate

   always_comb begin
      nxt    = cur_q;
      fall_d = fall_q;
      roll_min = (cur_q.sec == 6'd59);
      roll_hr  = roll_min && (cur_q.min == 6'd59);
      spring_fwd = dst_gate && (cur_q.month == 4'd4) && (cur_q.dow == 3'd1) &&
                   (cur_q.date <= 5'd7) && (cur_q.hour == 5'd1);
      fall_back  = dst_gate && (cur_q.month == 4'd10) && (cur_q.dow == 3'd1) &&
                   (cur_q.date >= 5'd25) && (cur_q.hour == 5'd1) && !fall_q;
      roll_day = roll_hr && (cur_q.hour == 5'd23);
      roll_mon = roll_day && (cur_q.date == days_in(cur_q.month, cur_q.year));
      roll_yr  = roll_mon && (cur_q.month == 4'd12);

      nxt.sec = roll_min ? 6'd0 : cur_q.sec + 6'd1;
      if (roll_min)
         nxt.min = (cur_q.min == 6'd59) ? 6'd0 : cur_q.min + 6'd1;
      if (roll_hr) begin
         if (spring_fwd) begin
            nxt.hour = 5'd3;
         end else if (fall_back) begin
            nxt.hour = 5'd1;
            fall_d   = 1'b1;
         end else begin
            nxt.hour = roll_day ? 5'd0 : cur_q.hour + 5'd1;
            if (cur_q.hour == 5'd1) fall_d = 1'b0;
         end
      end
      if (roll_day) begin
         nxt.dow  = (cur_q.dow == 3'd7) ? 3'd1 : cur_q.dow + 3'd1;
         nxt.date = roll_mon ? 5'd1 : cur_q.date + 5'd1;
      end
      if (roll_mon)
         nxt.month = roll_yr ? 4'd1 : cur_q.month + 4'd1;
      if (roll_yr)
         nxt.year = (cur_q.year == YEAR_TOP) ? 7'd0 : cur_q.year + 7'd1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '{sec: 6'd0, min: 6'd0, hour: 5'd0, dow: 3'd1,
                     date: 5'd1, month: 4'd1, year: 7'd0};
         fall_q <= 1'b0;
      end else if (ld_en) begin
         cur_q  <= ld_val;
         fall_q <= 1'b0;
      end else if (adv) begin
         cur_q  <= nxt;
         fall_q <= fall_d;
      end
   end

   assign now = cur_q;

endmodule

// File: rtl/rtc_field_encode.sv
module rtc_field_encode
   import rtc_cal_pkg::*;
(
   input  rtc_time_t                   now,
   input  logic                        bcd,
   input  logic                        h24,
   output logic [FIELD_CNT-1:0][7:0]   enc
);

   logic [FIELD_CNT-1:0][6:0] raw;

   assign raw[IDX_SEC]   = {1'b0, now.sec};
   assign raw[IDX_MIN]   = {1'b0, now.min};
   assign raw[IDX_HOUR]  = {2'b0, now.hour};
   assign raw[IDX_DOW]   = {4'b0, now.dow};
   assign raw[IDX_DATE]  = {2'b0, now.date};
   assign raw[IDX_MONTH] = {3'b0, now.month};
   assign raw[IDX_YEAR]  = now.year;

   generate
      for (genvar i = 0; i < FIELD_CNT; i++) begin : g_fld
         if (i == IDX_HOUR) begin : g_hr
            assign enc[i] = enc_hour(raw[i], bcd, h24);
         end else begin : g_plain
            assign enc[i] = enc_value(raw[i], bcd);
         end
      end
   endgenerate

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
   parameter int         N      = 3,
   parameter logic [1:0] DC_TAG = 2'b11
) (
   input  logic [N-1:0][7:0] alm,
   input  logic [N-1:0][7:0] live,
   output logic              all_hit
);

   logic [N-1:0] hit;

   generate
      for (genvar i = 0; i < N; i++) begin : g_cmp
         assign hit[i] = (alm[i][7:6] == DC_TAG) || (alm[i] == live[i]);
      end
   endgenerate

   assign all_hit = &hit;

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int         YEAR_MAX     = 99,
   parameter bit         DST_OPT      = 1'b1,
   parameter logic [1:0] ALARM_DC_TAG = 2'b11
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sec_tick,
   input  logic       ld_en,
   input  logic [5:0] ld_sec,
   input  logic [5:0] ld_min,
   input  logic [4:0] ld_hour,
   input  logic [2:0] ld_dow,
   input  logic [4:0] ld_date,
   input  logic [3:0] ld_month,
   input  logic [6:0] ld_year,
   input  logic       bcd_mode,
   input  logic       mode_24h,
   input  logic       dst_en,
   input  logic       freeze,
   input  logic [7:0] alm_sec,
   input  logic [7:0] alm_min,
   input  logic [7:0] alm_hour,
   output logic [7:0] out_sec,
   output logic [7:0] out_min,
   output logic [7:0] out_hour,
   output logic [7:0] out_dow,
   output logic [7:0] out_date,
   output logic [7:0] out_month,
   output logic [7:0] out_year,
   output logic       upd_done,
   output logic       alarm_hit
);

   localparam int ALM_CNT = IDX_HOUR + 1;

   generate
      if (YEAR_MAX < 3 || YEAR_MAX > 99 || ((YEAR_MAX + 1) % 4) != 0) begin : g_bad_year
         $error("YEAR_MAX must be 3..99 and one less than a multiple of four");
      end
   endgenerate

   rtc_time_t                 ld_val, now;
   logic [FIELD_CNT-1:0][7:0] enc, copy_q;
   logic [ALM_CNT-1:0][7:0]   alm_vec;
   logic                      adv, adv_q, upd_q, alm_q, match;

   assign adv    = sec_tick && !ld_en;
   assign ld_val = '{sec: ld_sec, min: ld_min, hour: ld_hour, dow: ld_dow,
                     date: ld_date, month: ld_month, year: ld_year};

   rtc_time_counter #(.YEAR_MAX(YEAR_MAX), .DST_OPT(DST_OPT)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .adv    (adv),
      .ld_en  (ld_en),
      .ld_val (ld_val),
      .dst_on (dst_en),
      .now    (now)
   );

   rtc_field_encode u_enc (
      .now (now),
      .bcd (bcd_mode),
      .h24 (mode_24h),
      .enc (enc)
   );

   assign alm_vec[IDX_SEC]  = alm_sec;
   assign alm_vec[IDX_MIN]  = alm_min;
   assign alm_vec[IDX_HOUR] = alm_hour;

   rtc_alarm_cmp #(.N(ALM_CNT), .DC_TAG(ALARM_DC_TAG)) u_alm (
      .alm     (alm_vec),
      .live    (enc[ALM_CNT-1:0]),
      .all_hit (match)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         copy_q <= '0;
         adv_q  <= 1'b0;
         upd_q  <= 1'b0;
         alm_q  <= 1'b0;
      end else begin
         if (!freeze) copy_q <= enc;
         adv_q <= adv;
         upd_q <= adv_q;
         alm_q <= adv_q && match;
      end
   end

   assign out_sec   = copy_q[IDX_SEC];
   assign out_min   = copy_q[IDX_MIN];
   assign out_hour  = copy_q[IDX_HOUR];
   assign out_dow   = copy_q[IDX_DOW];
   assign out_date  = copy_q[IDX_DATE];
   assign out_month = copy_q[IDX_MONTH];
   assign out_year  = copy_q[IDX_YEAR];
   assign upd_done  = upd_q;
   assign alarm_hit = alm_q;

endmodule

// File: rtl/rtc_calendar_core_chk.sv
module rtc_calendar_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       sec_tick,
   input logic       ld_en,
   input logic       freeze,
   input logic       bcd_mode,
   input logic       mode_24h,
   input logic [7:0] out_sec,
   input logic [7:0] out_min,
   input logic [7:0] out_hour,
   input logic       upd_done,
   input logic       alarm_hit
);

   AST_UPD_AFTER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_tick && !ld_en) |-> ##2 upd_done);  // R7

   AST_UPD_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      upd_done |-> $past(sec_tick && !ld_en, 2));  // R7

   AST_LOAD_DROPS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |-> ##2 !upd_done);  // R11

   AST_ALARM_WITH_UPD: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_hit |-> upd_done);  // R8

   AST_FROZEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(freeze) |-> ($stable(out_sec) && $stable(out_min) && $stable(out_hour)));  // R9

   AST_SEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !freeze && !bcd_mode) |-> (out_sec < 8'd60));  // R2

   AST_HOUR24_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !freeze && mode_24h && !bcd_mode) |-> (out_hour < 8'd24));  // R5

   AST_HOUR12_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !freeze && !mode_24h && !bcd_mode) |->
         (out_hour[6:0] >= 7'd1 && out_hour[6:0] <= 7'd12));  // R5

endmodule

bind rtc_calendar_core rtc_calendar_core_chk i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sec_tick  (sec_tick),
   .ld_en     (ld_en),
   .freeze    (freeze),
   .bcd_mode  (bcd_mode),
   .mode_24h  (mode_24h),
   .out_sec   (out_sec),
   .out_min   (out_min),
   .out_hour  (out_hour),
   .upd_done  (upd_done),
   .alarm_hit (alarm_hit)
);

// File: tb/test_rtc_calendar_core.sv
module test_rtc_calendar_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sec_tick = 1'b0;
   logic       ld_en = 1'b0;
   logic [5:0] ld_sec = '0;
   logic [5:0] ld_min = '0;
   logic [4:0] ld_hour = '0;
   logic [2:0] ld_dow = 3'd1;
   logic [4:0] ld_date = 5'd1;
   logic [3:0] ld_month = 4'd1;
   logic [6:0] ld_year = '0;
   logic       bcd_mode = 1'b1;
   logic       mode_24h = 1'b1;
   logic       dst_en = 1'b0;
   logic       freeze = 1'b0;
   logic [7:0] alm_sec = 8'h3F;
   logic [7:0] alm_min = 8'h3F;
   logic [7:0] alm_hour = 8'h3F;
   logic [7:0] out_sec, out_min, out_hour, out_dow, out_date, out_month, out_year;
   logic       upd_done, alarm_hit;

   rtc_calendar_core i_rtc_calendar_core (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .ld_en(ld_en),
      .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour), .ld_dow(ld_dow),
      .ld_date(ld_date), .ld_month(ld_month), .ld_year(ld_year),
      .bcd_mode(bcd_mode), .mode_24h(mode_24h), .dst_en(dst_en), .freeze(freeze),
      .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
      .out_sec(out_sec), .out_min(out_min), .out_hour(out_hour), .out_dow(out_dow),
      .out_date(out_date), .out_month(out_month), .out_year(out_year),
      .upd_done(upd_done), .alarm_hit(alarm_hit)
   );

   always #2 clk = ~clk;  // 250 MHz

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // bench time model
   int m_sec, m_min, m_hr, m_dow, m_date, m_mon, m_yr;
   bit m_fell;

   task automatic check(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   function automatic int mdays(int mo, int yr);
      if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
      if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
      return 31;
   endfunction

   function automatic logic [7:0] b_enc(int v);
      if (bcd_mode) return 8'((v / 10) * 16 + (v % 10));
      return 8'(v);
   endfunction

   function automatic logic [7:0] b_hour(int h);
      int h12;
      if (mode_24h) return b_enc(h);
      h12 = h % 12;
      if (h12 == 0) h12 = 12;
      return b_enc(h12) | ((h >= 12) ? 8'h80 : 8'h00);
   endfunction

   function automatic bit fld_ok(logic [7:0] a, logic [7:0] l);
      return (a[7:6] == 2'b11) || (a == l);
   endfunction

   task automatic model_step();
      m_sec++;
      if (m_sec < 60) return;
      m_sec = 0;
      m_min++;
      if (m_min < 60) return;
      m_min = 0;
      if (dst_en && m_mon == 4 && m_dow == 1 && m_date <= 7 && m_hr == 1) begin
         m_hr = 3;
         return;
      end
      if (dst_en && m_mon == 10 && m_dow == 1 && m_date >= 25 && m_hr == 1 && !m_fell) begin
         m_fell = 1'b1;
         return;
      end
      if (m_hr == 1) m_fell = 1'b0;
      m_hr++;
      if (m_hr < 24) return;
      m_hr = 0;
      m_dow = (m_dow % 7) + 1;
      m_date++;
      if (m_date <= mdays(m_mon, m_yr)) return;
      m_date = 1;
      m_mon++;
      if (m_mon <= 12) return;
      m_mon = 1;
      m_yr = (m_yr + 1) % 100;
   endtask

   function automatic logic [55:0] exp_vec();
      return {b_enc(m_yr), b_enc(m_mon), b_enc(m_date), b_enc(m_dow),
              b_hour(m_hr), b_enc(m_min), b_enc(m_sec)};
   endfunction

   function automatic logic [55:0] act_vec();
      return {out_year, out_month, out_date, out_dow, out_hour, out_min, out_sec};
   endfunction

   task automatic chk_time(string rq);
      check(act_vec() == exp_vec(), rq, 64'(act_vec()), 64'(exp_vec()));
   endtask

   // tick: ends after the second edge, when upd_done and the new time are visible
   task automatic tick(string rq, bit chk_out);
      bit ea;
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      model_step();
      @(negedge clk);
      check(upd_done == 1'b1, "R7 upd_done", 64'(upd_done), 64'd1);
      ea = fld_ok(alm_sec, b_enc(m_sec)) && fld_ok(alm_min, b_enc(m_min)) &&
           fld_ok(alm_hour, b_hour(m_hr));
      check(alarm_hit == ea, "R8 alarm_hit", 64'(alarm_hit), 64'(ea));
      if (chk_out) chk_time(rq);
   endtask

   task automatic do_load(int h, int mi, int s, int dw, int dt, int mo, int yr);
      @(negedge clk);
      ld_hour = 5'(h); ld_min = 6'(mi); ld_sec = 6'(s); ld_dow = 3'(dw);
      ld_date = 5'(dt); ld_month = 4'(mo); ld_year = 7'(yr);
      ld_en = 1'b1;
      @(negedge clk) ld_en = 1'b0;
      m_hr = h; m_min = mi; m_sec = s; m_dow = dw; m_date = dt; m_mon = mo; m_yr = yr;
      m_fell = 1'b0;
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin : main
      logic [55:0] held;
      repeat (3) @(negedge clk);
      // R1: reset state
      check({act_vec(), upd_done, alarm_hit} == 58'd0, "R1 reset outputs",
            64'({act_vec(), upd_done, alarm_hit}), 64'd0);
      rst_n = 1'b1;
      m_sec = 0; m_min = 0; m_hr = 0; m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0; m_fell = 0;
      @(negedge clk);
      chk_time("R1 reset counter values");

      // R2/R4: long BCD run across midnight
      do_load(22, 59, 0, 3, 15, 6, 24);
      for (int i = 0; i < 3700; i++) tick("R2 R4 bcd sweep", 1'b1);
      @(negedge clk);
      check(upd_done == 1'b0, "R7 one-cycle pulse", 64'(upd_done), 64'd0);

      // R3/R4: binary run across century end
      bcd_mode = 1'b0;
      do_load(23, 58, 30, 7, 31, 12, 99);
      for (int i = 0; i < 200; i++) tick("R3 R4 year wrap binary", 1'b1);
      check(out_year == 8'd0, "R3 year 99 to 0", 64'(out_year), 64'd0);

      // R3: month ends in several years
      bcd_mode = 1'b1;
      foreach (m_yr_list[k]) begin
         for (int mo = 1; mo <= 12; mo++) begin
            do_load(23, 59, 59, 7, mdays(mo, m_yr_list[k]), mo, m_yr_list[k]);
            tick("R3 month end", 1'b1);
         end
      end
      do_load(23, 59, 59, 2, 28, 2, 8);
      tick("R3 leap feb 28 to 29", 1'b1);
      check(out_date == 8'h29, "R3 leap date 29", 64'(out_date), 64'h29);

      // R5: 12-hour sweep in both encodings
      mode_24h = 1'b0;
      for (int b = 0; b < 2; b++) begin
         bcd_mode = b[0];
         for (int h = 0; h < 24; h++) begin
            do_load(h, 59, 59, 2, 10, 5, 10);
            tick("R5 12h hour step", 1'b1);
         end
      end
      bcd_mode = 1'b1;
      do_load(11, 59, 59, 2, 10, 5, 10);
      tick("R5 11 to 12 PM", 1'b1);
      check(out_hour == 8'h92, "R5 12 PM byte", 64'(out_hour), 64'h92);
      mode_24h = 1'b1;

      // R6: daylight saving
      bcd_mode = 1'b0;
      dst_en = 1'b1;
      do_load(1, 59, 59, 1, 5, 4, 20);
      tick("R6 spring forward", 1'b1);
      check(out_hour == 8'd3, "R6 spring hour 3", 64'(out_hour), 64'd3);
      do_load(1, 59, 59, 1, 12, 4, 20);
      tick("R6 april later sunday", 1'b1);
      do_load(1, 59, 59, 1, 27, 10, 20);
      tick("R6 fall back", 1'b1);
      check(out_hour == 8'd1, "R6 fall hour 1", 64'(out_hour), 64'd1);
      for (int i = 0; i < 3600; i++) tick("R6 repeated hour", 1'b1);
      check(out_hour == 8'd2, "R6 second pass to 2", 64'(out_hour), 64'd2);
      do_load(1, 59, 59, 1, 20, 10, 20);
      tick("R6 october early sunday", 1'b1);
      dst_en = 1'b0;
      do_load(1, 59, 59, 1, 5, 4, 20);
      tick("R6 disabled", 1'b1);
      check(out_hour == 8'd2, "R6 disabled hour 2", 64'(out_hour), 64'd2);

      // R8: alarms
      bcd_mode = 1'b1;
      alm_sec = 8'hC0; alm_min = 8'hC5; alm_hour = 8'hFF;
      do_load(5, 5, 5, 3, 3, 3, 3);
      for (int i = 0; i < 5; i++) tick("R8 all wildcard", 1'b1);
      alm_sec = 8'h31; alm_min = 8'h20; alm_hour = 8'h10;
      do_load(10, 20, 25, 3, 3, 3, 3);
      for (int i = 0; i < 10; i++) tick("R8 exact match", 1'b1);
      mode_24h = 1'b0;
      alm_sec = 8'h00; alm_min = 8'hC0; alm_hour = 8'h83;
      do_load(14, 59, 58, 3, 3, 3, 3);
      for (int i = 0; i < 70; i++) tick("R8 PM hour wildcard minute", 1'b1);
      mode_24h = 1'b1;
      alm_sec = 8'h3F; alm_min = 8'h3F; alm_hour = 8'h3F;

      // R9/R10: freeze
      do_load(8, 0, 0, 4, 4, 4, 4);
      @(negedge clk) freeze = 1'b1;
      held = act_vec();
      for (int i = 0; i < 4; i++) tick("R9 frozen", 1'b0);
      check(act_vec() == held, "R9 outputs held", 64'(act_vec()), 64'(held));
      @(negedge clk) freeze = 1'b0;
      @(negedge clk);
      chk_time("R10 release reload");

      // R11: load with a coincident tick
      @(negedge clk);
      ld_hour = 5'd17; ld_min = 6'd45; ld_sec = 6'd59; ld_dow = 3'd6;
      ld_date = 5'd9; ld_month = 4'd9; ld_year = 7'd44;
      ld_en = 1'b1; sec_tick = 1'b1;
      @(negedge clk) begin ld_en = 1'b0; sec_tick = 1'b0; end
      m_hr = 17; m_min = 45; m_sec = 59; m_dow = 6; m_date = 9; m_mon = 9; m_yr = 44;
      @(negedge clk);
      chk_time("R11 load wins over tick");
      check(upd_done == 1'b0, "R11 no upd_done", 64'(upd_done), 64'd0);
      tick("R11 advance after load", 1'b1);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   int m_yr_list[4] = '{3, 4, 99, 0};

endmodule